// File: doc/BRIEF.md
# Peripheral Window Select and Wait-State Sequencer

This block sits on a 24-bit processor address bus and recognises three 64 KB peripheral windows: a spare expansion slot, a network controller and a real-time clock. When a bus cycle is started with the active-low address strobe inside one of those windows, it drives that window's active-low select. It also drives the active-low I/O read or I/O write strobe, whichever matches the cycle direction. Longword address bits 5..2 go to the peripheral as a 4-bit register index, and the peripheral exchanges data on byte lane D23..D16, which this block does not buffer.

The processor cycle is stretched by an active-low wait output for a fixed number of clocks. The count depends on the window and on the direction, and a write always takes one more wait than a read. A one-clock acknowledge then tells the processor that the transfer is done. Select and strobe stay low until the processor releases the address strobe. No recovery time is enforced between two accesses to the same slow peripheral; software must space them.

The sequencer has four states:
- `ST_IDLE`: waits for a decoded cycle.
- `ST_WAIT`: counts wait states.
- `ST_ACK`: the acknowledge clock.
- `ST_HOLD`: selects are held until the strobe is released.

Its transitions are:
- start: `ST_IDLE` to `ST_WAIT`, or straight to `ST_ACK` when the wait count is zero.
- expire: `ST_WAIT` to `ST_ACK`.
- settle: `ST_ACK` to `ST_HOLD`.
- release: any active state to `ST_IDLE` once the address strobe is high.

Top module: `pcsw_top`

## Requirements
- R1: With the address strobe low in idle, an address whose bits 23..16 equal 0xD8 drives the spare select low, and no other select.
- R2: Address bits 23..16 equal to 0xD9 drive the network select low, and no other select.
- R3: Address bits 23..16 equal to 0xDC drive the clock select low, and no other select.
- R4: Any other address drives no select, no strobe and no acknowledge, and the wait output stays high.
- R5: Spare-window and clock-window cycles hold the wait output low for exactly 3 clocks on a read and 4 on a write.
- R6: Network-window cycles hold the wait output low for 0 clocks on a read and 1 clock on a write.
- R7: At most one select is low at a time. The read strobe (`rd_nwr_i`=1) or the write strobe (`rd_nwr_i`=0) is low only together with a select, and never both strobes at once.
- R8: `pa_o` carries address bits 5..2 of the accepted cycle and is stable while a select stays low.
- R9: The acknowledge is high for exactly one clock, the clock right after the last wait clock (or the first clock of the cycle when there are no waits), and the wait output is high during it.
- R10: Select and strobe remain low through the wait and acknowledge clocks and after them while the address strobe stays low. They go high on the first clock after the address strobe is seen high, which also cuts short an unfinished wait count.
- R11: A new access is accepted on the very next clock after the previous one has returned to idle, with no enforced gap.
- R12: A synchronous reset drives all selects and strobes high, the wait output high and the acknowledge low on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 24 | Processor address |
| as_n_i | input | 1 | Address/cycle strobe, active low |
| rd_nwr_i | input | 1 | 1 = read cycle, 0 = write cycle |
| cs_spare_n_o | output | 1 | Spare-window select, active low |
| cs_net_n_o | output | 1 | Network-window select, active low |
| cs_rtc_n_o | output | 1 | Clock-window select, active low |
| iord_n_o | output | 1 | I/O read strobe, active low |
| iowr_n_o | output | 1 | I/O write strobe, active low |
| pa_o | output | 4 | Peripheral register index (address bits 5..2) |
| ack_o | output | 1 | Cycle acknowledge, one-clock pulse, active high |
| wait_n_o | output | 1 | Wait request, active low |

## Verification
The embedded properties guard the invariants on every clock:
- select exclusivity;
- strobe/select pairing;
- index stability during a select;
- release of select and strobe after the address strobe rises;
- reset clearing;
- the acknowledge following counter expiry, and never lasting two clocks;
- the counter never being decremented at zero.

The exact wait lengths per window and direction, the decode boundaries around each window, and early abort are visible only in the bench's scenarios. The same holds for holding the selects after the acknowledge and for back-to-back acceptance, which the bench drives and times at the ports.

// File: rtl/pcsw_pkg.sv
package pcsw_pkg;

    // Decoded peripheral window; encoding is shared by decoder and sequencer.
    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_SPARE = 2'd1,
        REG_NET   = 2'd2,
        REG_RTC   = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACK  = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_e;

    localparam int NUM_WIN = 3;

endpackage

// File: rtl/pcsw_decode.sv
module pcsw_decode
    import pcsw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WIN_W  = 16,
    parameter int CNT_W  = 3,
    parameter logic [ADDR_W-1:0] SPARE_BASE = 24'hD80000,
    parameter logic [ADDR_W-1:0] NET_BASE   = 24'hD90000,
    parameter logic [ADDR_W-1:0] RTC_BASE   = 24'hDC0000,
    parameter int SPARE_RD = 3,
    parameter int SPARE_WR = 4,
    parameter int NET_RD   = 0,
    parameter int NET_WR   = 1,
    parameter int RTC_RD   = 3,
    parameter int RTC_WR   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_nwr,
    output region_e           region,
    output logic [CNT_W-1:0]  waits
);

    localparam logic [ADDR_W-1:0] BASES [NUM_WIN] = '{SPARE_BASE, NET_BASE, RTC_BASE};
    localparam int RD_W [NUM_WIN] = '{SPARE_RD, NET_RD, RTC_RD};
    localparam int WR_W [NUM_WIN] = '{SPARE_WR, NET_WR, RTC_WR};

    logic [NUM_WIN-1:0] hit_vec;
    logic [CNT_W-1:0]   wait_vec [NUM_WIN];

    // One comparator and one wait selector per window.
    generate
        for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
            assign hit_vec[g]  = (addr[ADDR_W-1:WIN_W] == BASES[g][ADDR_W-1:WIN_W]);
            assign wait_vec[g] = rd_nwr ? CNT_W'(RD_W[g]) : CNT_W'(WR_W[g]);
        end
    endgenerate

    always_comb begin
        region = REG_NONE;
        waits  = '0;
        if (hit_vec[0]) begin
            region = REG_SPARE;
            waits  = wait_vec[0];
        end else if (hit_vec[1]) begin
            region = REG_NET;
            waits  = wait_vec[1];
        end else if (hit_vec[2]) begin
            region = REG_RTC;
            waits  = wait_vec[2];
        end
    end

    // Windows never overlap (R7)
    always_comb begin
        assert_windows_disjoint_R7: assert ($onehot0(hit_vec) || $isunknown(hit_vec));
    end

endmodule

// File: rtl/pcsw_wait_ctr.sv
module pcsw_wait_ctr #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));

    // Wait count never wraps below zero (R5, R6)
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (dec && !clr && !load) |-> (cnt != '0));

endmodule

// File: rtl/pcsw_seq.sv
module pcsw_seq
    import pcsw_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int PA_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             rd_nwr,
    input  region_e          region_in,
    input  logic [CNT_W-1:0] waits_in,
    input  logic [PA_W-1:0]  pa_in,
    input  logic             ctr_last,
    output logic             ctr_load,
    output logic             ctr_dec,
    output logic             ctr_clr,
    output logic [2:0]       cs_n,
    output logic             iord_n,
    output logic             iowr_n,
    output logic             wait_n,
    output logic             ack,
    output logic [PA_W-1:0]  pa
);

    seq_state_e state, state_nx;
    region_e    region_q;
    logic       rd_q;
    logic       start;

    assign start    = (state == ST_IDLE) && !as_n && (region_in != REG_NONE);
    assign ctr_load = start;
    assign ctr_dec  = (state == ST_WAIT) && !as_n;
    assign ctr_clr  = (state != ST_IDLE) && as_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (waits_in == '0) ? ST_ACK : ST_WAIT;
            ST_WAIT: begin
                if (as_n)          state_nx = ST_IDLE;
                else if (ctr_last) state_nx = ST_ACK;
            end
            ST_ACK:  state_nx = as_n ? ST_IDLE : ST_HOLD;
            ST_HOLD: if (as_n) state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            region_q <= REG_NONE;
            rd_q     <= 1'b1;
            pa       <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                region_q <= region_in;
                rd_q     <= rd_nwr;
                pa       <= pa_in;
            end
        end
    end

    always_comb begin
        cs_n   = 3'b111;
        iord_n = 1'b1;
        iowr_n = 1'b1;
        wait_n = 1'b1;
        ack    = 1'b0;
        if (state != ST_IDLE) begin
            unique case (region_q)
                REG_SPARE: cs_n = 3'b110;
                REG_NET:   cs_n = 3'b101;
                REG_RTC:   cs_n = 3'b011;
                REG_NONE:  cs_n = 3'b111;
            endcase
            iord_n = !rd_q;
            iowr_n = rd_q;
        end
        if (state == ST_WAIT) wait_n = 1'b0;
        if (state == ST_ACK)  ack    = 1'b1;
    end

    // Counter expiry in a live cycle is followed by the acknowledge (R9)
    assert_ack_after_expiry_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && ctr_last && !as_n) |=> ack);

    // Acknowledge lasts a single clock (R9)
    assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

endmodule

// File: rtl/pcsw_top.sv
module pcsw_top
    import pcsw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int WIN_W  = 16,
    parameter int PA_LO  = 2,
    parameter int PA_W   = 4,
    parameter logic [ADDR_W-1:0] SPARE_BASE = 24'hD80000,
    parameter logic [ADDR_W-1:0] NET_BASE   = 24'hD90000,
    parameter logic [ADDR_W-1:0] RTC_BASE   = 24'hDC0000,
    parameter int SPARE_RD = 3,
    parameter int SPARE_WR = 4,
    parameter int NET_RD   = 0,
    parameter int NET_WR   = 1,
    parameter int RTC_RD   = 3,
    parameter int RTC_WR   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              as_n_i,
    input  logic              rd_nwr_i,
    output logic              cs_spare_n_o,
    output logic              cs_net_n_o,
    output logic              cs_rtc_n_o,
    output logic              iord_n_o,
    output logic              iowr_n_o,
    output logic [PA_W-1:0]   pa_o,
    output logic              ack_o,
    output logic              wait_n_o
);

    localparam int MAX_A = (SPARE_RD > SPARE_WR) ? SPARE_RD : SPARE_WR;
    localparam int MAX_B = (NET_RD > NET_WR) ? NET_RD : NET_WR;
    localparam int MAX_C = (RTC_RD > RTC_WR) ? RTC_RD : RTC_WR;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_W  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int CNT_W  = (MAX_W < 1) ? 1 : $clog2(MAX_W + 1);

    region_e          region;
    logic [CNT_W-1:0] waits;
    logic             ctr_load, ctr_dec, ctr_clr, ctr_last;
    logic [2:0]       cs_n;

    pcsw_decode #(
        .ADDR_W(ADDR_W), .WIN_W(WIN_W), .CNT_W(CNT_W),
        .SPARE_BASE(SPARE_BASE), .NET_BASE(NET_BASE), .RTC_BASE(RTC_BASE),
        .SPARE_RD(SPARE_RD), .SPARE_WR(SPARE_WR),
        .NET_RD(NET_RD), .NET_WR(NET_WR),
        .RTC_RD(RTC_RD), .RTC_WR(RTC_WR)
    ) u_decode (
        .addr   (addr_i),
        .rd_nwr (rd_nwr_i),
        .region (region),
        .waits  (waits)
    );

    pcsw_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clr      (ctr_clr),
        .load     (ctr_load),
        .load_val (waits),
        .dec      (ctr_dec),
        .last     (ctr_last)
    );

    pcsw_seq #(.CNT_W(CNT_W), .PA_W(PA_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .as_n      (as_n_i),
        .rd_nwr    (rd_nwr_i),
        .region_in (region),
        .waits_in  (waits),
        .pa_in     (addr_i[PA_LO +: PA_W]),
        .ctr_last  (ctr_last),
        .ctr_load  (ctr_load),
        .ctr_dec   (ctr_dec),
        .ctr_clr   (ctr_clr),
        .cs_n      (cs_n),
        .iord_n    (iord_n_o),
        .iowr_n    (iowr_n_o),
        .wait_n    (wait_n_o),
        .ack       (ack_o),
        .pa        (pa_o)
    );

    assign cs_spare_n_o = cs_n[0];
    assign cs_net_n_o   = cs_n[1];
    assign cs_rtc_n_o   = cs_n[2];

    // At most one select low (R7)
    assert_cs_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // Strobes only with a select, never together (R7)
    assert_strobe_with_cs_R7: assert property (@(posedge clk) disable iff (rst)
        (!iord_n_o || !iowr_n_o) |-> (cs_n != 3'b111 && (iord_n_o || iowr_n_o)));

    // Index steady while a select is held (R8)
    assert_pa_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_n != 3'b111 && $past(cs_n) != 3'b111) |-> $stable(pa_o));

    // Released address strobe ends the cycle on the next clock (R10)
    assert_release_R10: assert property (@(posedge clk) disable iff (rst)
        as_n_i |=> (cs_n == 3'b111 && iord_n_o && iowr_n_o && wait_n_o));

    // Miss in idle selects nothing (R4)
    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!as_n_i && region == REG_NONE && cs_n == 3'b111) |=> (cs_n == 3'b111 && !ack_o));

    // Reset clears every output (R12)
    assert_reset_clear_R12: assert property (@(posedge clk)
        rst |=> (cs_n == 3'b111 && iord_n_o && iowr_n_o && wait_n_o && !ack_o));

endmodule

// File: tb/pcsw_top_tb_top.sv
module pcsw_top_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 12;

    // {addr[23:0], rd, region[1:0] (0 none,1 spare,2 net,3 rtc), waits[2:0], pad[1:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {24'hD80000, 1'b1, 2'd1, 3'd3, 2'd0},
        {24'hD8FFFC, 1'b0, 2'd1, 3'd4, 2'd0},
        {24'hD9003C, 1'b1, 2'd2, 3'd0, 2'd0},
        {24'hD90010, 1'b0, 2'd2, 3'd1, 2'd0},
        {24'hDC0024, 1'b1, 2'd3, 3'd3, 2'd0},
        {24'hDCFFF0, 1'b0, 2'd3, 3'd4, 2'd0},
        {24'hD7FFFC, 1'b1, 2'd0, 3'd0, 2'd0},
        {24'hDA0000, 1'b0, 2'd0, 3'd0, 2'd0},
        {24'hDB0000, 1'b1, 2'd0, 3'd0, 2'd0},
        {24'hDD0000, 1'b1, 2'd0, 3'd0, 2'd0},
        {24'hD90004, 1'b1, 2'd2, 3'd0, 2'd0},
        {24'hD8001C, 1'b0, 2'd1, 3'd4, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] addr_i;
    logic        as_n_i;
    logic        rd_nwr_i;
    logic        cs_spare_n_o, cs_net_n_o, cs_rtc_n_o;
    logic        iord_n_o, iowr_n_o;
    logic [3:0]  pa_o;
    logic        ack_o, wait_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pcsw_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .addr_i       (addr_i),
        .as_n_i       (as_n_i),
        .rd_nwr_i     (rd_nwr_i),
        .cs_spare_n_o (cs_spare_n_o),
        .cs_net_n_o   (cs_net_n_o),
        .cs_rtc_n_o   (cs_rtc_n_o),
        .iord_n_o     (iord_n_o),
        .iowr_n_o     (iowr_n_o),
        .pa_o         (pa_o),
        .ack_o        (ack_o),
        .wait_n_o     (wait_n_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cs(input logic [1:0] r);
        case (r)
            2'd1:    return 3'b110;
            2'd2:    return 3'b101;
            2'd3:    return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic string reg_tag(input logic [1:0] r);
        case (r)
            2'd1:    return "R1";
            2'd2:    return "R2";
            2'd3:    return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [2:0] obs_cs();
        return {cs_rtc_n_o, cs_net_n_o, cs_spare_n_o};
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_check(input string req);
        check(req, {obs_cs(), iord_n_o, iowr_n_o, wait_n_o, ack_o}, {3'b111, 1'b1, 1'b1, 1'b1, 1'b0});
    endtask

    // Starts at a negedge, returns at a negedge with the block idle again.
    task automatic access(input logic [23:0] a, input logic rd, input logic [1:0] r,
                          input int nw, input int hold);
        string wt;
        wt = (r == 2'd2) ? "R6" : "R5";
        addr_i   = a;
        rd_nwr_i = rd;
        as_n_i   = 1'b0;
        if (r == 2'd0) begin
            for (int k = 0; k < 4; k++) begin
                step();
                idle_check("R4 miss stays quiet");
            end
        end else begin
            for (int k = 1; k <= nw + 1; k++) begin
                step();
                check({reg_tag(r), " select"}, obs_cs(), exp_cs(r));
                check("R7 strobe", {iord_n_o, iowr_n_o}, {!rd, rd});
                check("R8 index", pa_o, a[5:2]);
                if (k <= nw) begin
                    check({wt, " wait low"}, {wait_n_o, ack_o}, 2'b00);
                end else begin
                    check("R9 ack after waits", {wait_n_o, ack_o}, 2'b11);
                end
            end
            for (int k = 0; k < hold; k++) begin
                step();
                check("R10 held after ack", {obs_cs(), ack_o, wait_n_o}, {exp_cs(r), 1'b0, 1'b1});
                check("R10 strobe held", {iord_n_o, iowr_n_o}, {!rd, rd});
            end
        end
        as_n_i = 1'b1;
        step();
        idle_check("R10 release");
    endtask

    initial begin
        rst      = 1'b1;
        addr_i   = '0;
        as_n_i   = 1'b1;
        rd_nwr_i = 1'b1;
        @(negedge clk);
        step();
        idle_check("R12 reset state");
        rst = 1'b0;
        step();

        // Vector table, run back to back
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][31:8], VEC[i][7], VEC[i][6:5], int'(VEC[i][4:2]), 0);
        end

        // R11: new access on the clock right after return to idle
        access(24'hDC0008, 1'b1, 2'd3, 3, 0);
        access(24'hDC0008, 1'b0, 2'd3, 4, 0);

        // R10: address strobe kept low after ack
        access(24'hD90030, 1'b0, 2'd2, 1, 3);

        // R10: early release cuts the wait count short
        addr_i = 24'hD80014; rd_nwr_i = 1'b1; as_n_i = 1'b0;
        step();
        check("R10 abort start", {obs_cs(), wait_n_o}, {3'b110, 1'b0});
        as_n_i = 1'b1;
        step();
        idle_check("R10 abort release");
        step();
        idle_check("R10 abort no late ack");
        access(24'hD80014, 1'b1, 2'd1, 3, 0);

        // R12: reset in the middle of a write
        addr_i = 24'hD80000; rd_nwr_i = 1'b0; as_n_i = 1'b0;
        step();
        step();
        check("R12 pre-reset wait", wait_n_o, 1'b0);
        rst = 1'b1;
        step();
        idle_check("R12 reset mid-cycle");
        as_n_i = 1'b1;
        rst = 1'b0;
        step();
        idle_check("R12 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule